// File: doc/BRIEF.md
# Fractional-N Clock Divider with Integer Bypass

This block divides a fast source clock by a programmable rational ratio `whole + num/den`. Every output period lasts a whole number of source cycles. A modulo-`den` numerator accumulator chooses, period by period, between the lower divisor `whole` and the upper divisor `whole + 1`. Over `den` periods exactly `num` of them take the upper divisor, so the long-run average frequency carries no error.

With every new period the block also reports a fixed-point phase-error word. This word tells a downstream fine-delay stage how far the edge just produced sits ahead of the ideal edge of an exact fractional clock. A divisor-select flag shows which divisor is active.

A bypass path skips the fractional logic and divides by a plain integer. Only the values 4 and 6 are legal there. In fractional mode the ratio must be at least 8. A configuration outside these limits raises an error flag and holds the output low.

Top module: `fracdiv_top`

## Requirements
- R1: In fractional mode, each period has length `whole + 1` when `acc + num >= den`, where `acc` is the accumulator residue; the residue then becomes `acc + num - den`. Otherwise the length is `whole` and the residue becomes `acc + num`. The residue starts at 0 when the divider starts.
- R2: At each rising edge of `clk_o` in fractional mode, `phase_err_o` equals `floor(residue * 2^PHASE_W / den)`. The residue is the one left after the update for the period that begins at that edge.
- R3: With bypass off, the configuration is an error when `whole < 8`, when `den == 0`, or when `num >= den`. `cfg_err_o` then goes high one cycle after the bad inputs are sampled, and `clk_o` stays low.
- R4: With bypass on, `whole` must be 4 or 6; any other value is a configuration error as in R3. For a legal value, every period is exactly `whole` cycles, `div_hi_o` is 0 and `phase_err_o` is 0.
- R5: `div_hi_o` is 1 for a period that uses the upper divisor `whole + 1` and 0 for one that uses `whole`. It changes together with the rising edge that starts the period.
- R6: A change of the ratio inputs takes effect only at the next period boundary. The period in progress keeps its length.
- R7: In every period of length D, `clk_o` is high for `floor(D/2)` source cycles starting at the rising edge, and low for the rest.
- R8: After reset, `clk_o`, `div_hi_o`, `phase_err_o` and `cfg_err_o` are 0. The first rising edge comes `whole` cycles after the first clock edge that samples `en_i` high with a legal configuration, that is, after one low priming period.
- R9: Sampling `en_i` low sends `clk_o` low on the next cycle and clears the accumulator. The next start therefore begins again from residue 0 with a priming period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Run enable |
| whole_i | input | INT_W | Integer part of the ratio; the divide value in bypass |
| num_i | input | FRAC_W | Fraction numerator |
| den_i | input | FRAC_W | Fraction denominator |
| bypass_i | input | 1 | Select the integer bypass path |
| clk_o | output | 1 | Divided clock |
| phase_err_o | output | PHASE_W | Lead of the produced edge over the ideal edge, in units of 2^-PHASE_W source cycles |
| div_hi_o | output | 1 | Upper divisor in use for the current period |
| cfg_err_o | output | 1 | Illegal configuration sampled |

## Verification
The scoreboard tracks the residue sequence through a full wrap of `den`. A divider that compared with `>` instead of `>=`, or forgot to subtract `den`, would show up at once as wrong period lengths, select flags or phase words. The bench rewrites the ratio in the middle of a period and switches bypass from 4 to 6; a design that loaded the new ratio at once would shorten or stretch the period already running. It also runs a ratio of 255 + 254/255 to catch divisor overflow, uses odd divisors to catch an off-by-one high time, and restarts after a disable to expose a residue that was not cleared. The error cases sit just outside the legal range (ratio 7, `num == den`, `den == 0`, bypass 5 and 8), where a loose range check would let the output toggle.

// File: rtl/fracdiv_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the fractional divider.
// Assumes: nothing beyond the constants below.
package fracdiv_pkg;
    // Period generator phases: stopped, priming period, normal running.
    typedef enum logic [1:0] {
        PG_IDLE  = 2'd0,
        PG_PRIME = 2'd1,
        PG_RUN   = 2'd2
    } pg_state_e;

    localparam int unsigned FRAC_MIN_RATIO = 8;
    localparam int unsigned BYP_RATIO_A    = 4;
    localparam int unsigned BYP_RATIO_B    = 6;
endpackage

// File: rtl/fracdiv_cfg_check.sv
`timescale 1ns/1ps
// Configuration legality check.
// Fractional mode needs whole >= 8, den != 0 and num < den; bypass mode
// accepts only whole == 4 or 6. Purely combinational.
module fracdiv_cfg_check
    import fracdiv_pkg::*;
#(
    parameter int unsigned INT_W  = 8,
    parameter int unsigned FRAC_W = 8
) (
    input  logic [INT_W-1:0]  whole_i,
    input  logic [FRAC_W-1:0] num_i,
    input  logic [FRAC_W-1:0] den_i,
    input  logic              bypass_i,
    output logic              bad_o
);
    logic frac_bad;
    logic byp_bad;

    // Fractional-mode limits.
    always_comb begin
        frac_bad = (whole_i < INT_W'(FRAC_MIN_RATIO)) ||
                   (den_i == '0) || (num_i >= den_i);
    end

    // Bypass-mode limits.
    always_comb begin
        byp_bad = !((whole_i == INT_W'(BYP_RATIO_A)) ||
                    (whole_i == INT_W'(BYP_RATIO_B)));
    end

    // Pick the check for the selected mode.
    always_comb begin
        bad_o = bypass_i ? byp_bad : frac_bad;
    end
endmodule

// File: rtl/fracdiv_accum.sv
`timescale 1ns/1ps
// Modulo-den numerator accumulator.
// On step_i it adds num and wraps at den; carry_o selects the upper divisor.
// Assumes num < den and that the caller steps only on legal configurations.
module fracdiv_accum #(
    parameter int unsigned FRAC_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clr_i,
    input  logic              step_i,
    input  logic [FRAC_W-1:0] num_i,
    input  logic [FRAC_W-1:0] den_i,
    output logic              carry_o,
    output logic [FRAC_W-1:0] res_next_o
);
    localparam int unsigned SUM_W = FRAC_W + 1;

    logic [FRAC_W-1:0] acc_q;
    logic [SUM_W-1:0]  sum;
    logic [SUM_W-1:0]  wrapped;

    // Candidate next residue and wrap decision.
    always_comb begin
        sum        = {1'b0, acc_q} + {1'b0, num_i};
        wrapped    = sum - {1'b0, den_i};
        carry_o    = (sum >= {1'b0, den_i});
        res_next_o = carry_o ? wrapped[FRAC_W-1:0] : sum[FRAC_W-1:0];
    end

    // Residue register: cleared on reset or stop, updated per period.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || clr_i) begin
            acc_q <= '0;
        end else if (step_i) begin
            acc_q <= res_next_o;
        end
    end

    // R1: a step from an in-range residue keeps the residue below den.
    p_acc_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i && !clr_i && (acc_q < den_i) && (num_i < den_i))
            |=> (acc_q < $past(den_i)));
endmodule

// File: rtl/fracdiv_phase_scale.sv
`timescale 1ns/1ps
// Residue-to-phase conversion: floor(res * 2^PHASE_W / den).
// Assumes res < den, so the quotient fits in PHASE_W bits. den == 0 yields 0.
module fracdiv_phase_scale #(
    parameter int unsigned FRAC_W  = 8,
    parameter int unsigned PHASE_W = 12
) (
    input  logic [FRAC_W-1:0]  res_i,
    input  logic [FRAC_W-1:0]  den_i,
    output logic [PHASE_W-1:0] phase_o
);
    localparam int unsigned NUM_W = FRAC_W + PHASE_W;

    logic [NUM_W-1:0] dividend;
    logic [NUM_W-1:0] divisor;

    // Scaled residue divided by a guarded denominator.
    always_comb begin
        dividend = {res_i, {PHASE_W{1'b0}}};
        divisor  = (den_i == '0) ? NUM_W'(1) : NUM_W'(den_i);
        phase_o  = (den_i == '0) ? '0 : PHASE_W'(dividend / divisor);
    end
endmodule

// File: rtl/fracdiv_period_gen.sv
`timescale 1ns/1ps
// Period counter and waveform shaper.
// Runs one low priming period of prime_div_i cycles, then periods whose
// length is loaded from next_div_i at each boundary. High time is
// floor(D/2) cycles from the period start. Assumes divisors >= 4.
module fracdiv_period_gen
    import fracdiv_pkg::*;
#(
    parameter int unsigned DIV_W = 9
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic [DIV_W-1:0] prime_div_i,
    input  logic [DIV_W-1:0] next_div_i,
    output logic             wrap_o,
    output logic             clk_o
);
    pg_state_e        state_q;
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] cur_div_q;
    logic             clk_q;
    logic             last;
    logic [DIV_W-1:0] cnt_inc;

    // Period-end detect and boundary strobe.
    always_comb begin
        last    = (cnt_q == cur_div_q - DIV_W'(1));
        cnt_inc = cnt_q + DIV_W'(1);
        wrap_o  = (state_q != PG_IDLE) && last && !stop_i;
    end

    // Sequencer: stop has priority, then start, then count and reload.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || stop_i) begin
            state_q   <= PG_IDLE;
            cnt_q     <= '0;
            cur_div_q <= '0;
            clk_q     <= 1'b0;
        end else begin
            case (state_q)
                PG_IDLE: begin
                    if (start_i) begin
                        state_q   <= PG_PRIME;
                        cnt_q     <= '0;
                        cur_div_q <= prime_div_i;
                        clk_q     <= 1'b0;
                    end
                end
                default: begin
                    if (last) begin
                        state_q   <= PG_RUN;
                        cnt_q     <= '0;
                        cur_div_q <= next_div_i;
                        clk_q     <= 1'b1;
                    end else begin
                        cnt_q <= cnt_inc;
                        clk_q <= (state_q == PG_RUN) && (cnt_inc < (cur_div_q >> 1));
                    end
                end
            endcase
        end
    end

    assign clk_o = clk_q;

    // R8: output edges only begin a running period.
    p_rise_at_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(clk_q) |-> (cnt_q == '0) && (state_q == PG_RUN));

    // R8: a stopped generator drives low.
    p_idle_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == PG_IDLE) |-> !clk_q);

    // R6: the period length is fixed until its boundary.
    p_len_kept_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((state_q != PG_IDLE) && !last && !stop_i) |=> (cur_div_q == $past(cur_div_q)));

    // R7: the high phase never runs past half the period.
    p_high_half_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clk_q && (state_q == PG_RUN)) |-> (cnt_q < (cur_div_q >> 1)));
endmodule

// File: rtl/fracdiv_top.sv
`timescale 1ns/1ps
// Fractional-N clock divider with a 4/6 integer bypass.
// Divides clk_i by whole + num/den, choosing whole or whole+1 each period,
// and reports a per-period phase-error word and divisor select.
// Assumes the ratio inputs are synchronous to clk_i.
module fracdiv_top #(
    parameter int unsigned INT_W   = 8,
    parameter int unsigned FRAC_W  = 8,
    parameter int unsigned PHASE_W = 12
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               en_i,
    input  logic [INT_W-1:0]   whole_i,
    input  logic [FRAC_W-1:0]  num_i,
    input  logic [FRAC_W-1:0]  den_i,
    input  logic               bypass_i,
    output logic               clk_o,
    output logic [PHASE_W-1:0] phase_err_o,
    output logic               div_hi_o,
    output logic               cfg_err_o
);
    localparam int unsigned DIV_W = INT_W + 1;

    logic               bad;
    logic               stop;
    logic               start;
    logic               wrap;
    logic               step;
    logic               carry;
    logic [FRAC_W-1:0]  res_next;
    logic [PHASE_W-1:0] phase_next;
    logic [DIV_W-1:0]   prime_div;
    logic [DIV_W-1:0]   next_div;
    logic               div_hi_q;
    logic [PHASE_W-1:0] phase_q;
    logic               cfg_err_q;

    fracdiv_cfg_check #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_cfg (
        .whole_i  (whole_i),
        .num_i    (num_i),
        .den_i    (den_i),
        .bypass_i (bypass_i),
        .bad_o    (bad)
    );

    // Run control and divisor selection.
    always_comb begin
        stop      = !en_i || bad;
        start     = en_i && !bad;
        step      = wrap && !bypass_i;
        prime_div = {1'b0, whole_i};
        next_div  = bypass_i ? {1'b0, whole_i}
                             : ({1'b0, whole_i} + DIV_W'(carry));
    end

    fracdiv_accum #(.FRAC_W(FRAC_W)) u_acc (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .clr_i      (stop),
        .step_i     (step),
        .num_i      (num_i),
        .den_i      (den_i),
        .carry_o    (carry),
        .res_next_o (res_next)
    );

    fracdiv_phase_scale #(.FRAC_W(FRAC_W), .PHASE_W(PHASE_W)) u_phase (
        .res_i   (res_next),
        .den_i   (den_i),
        .phase_o (phase_next)
    );

    fracdiv_period_gen #(.DIV_W(DIV_W)) u_gen (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .start_i     (start),
        .stop_i      (stop),
        .prime_div_i (prime_div),
        .next_div_i  (next_div),
        .wrap_o      (wrap),
        .clk_o       (clk_o)
    );

    // Per-period status, loaded at each boundary and cleared on stop.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || stop) begin
            div_hi_q <= 1'b0;
            phase_q  <= '0;
        end else if (wrap) begin
            div_hi_q <= step && carry;
            phase_q  <= bypass_i ? '0 : phase_next;
        end
    end

    // Registered configuration-error flag.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cfg_err_q <= 1'b0;
        end else begin
            cfg_err_q <= bad;
        end
    end

    assign div_hi_o    = div_hi_q;
    assign phase_err_o = phase_q;
    assign cfg_err_o   = cfg_err_q;

    // R3: an error flag always comes with a low output.
    p_err_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_err_o |-> !clk_o);

    // R3: a fractional ratio under the minimum is flagged.
    p_small_ratio_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!bypass_i && (whole_i < INT_W'(8))) |=> cfg_err_o);

    // R4: bypass periods carry no phase word and no upper-divisor flag.
    p_byp_flat_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wrap && bypass_i) |=> (!div_hi_o && (phase_err_o == '0)));

    // R9: disabling drives the output low on the next cycle.
    p_disable_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> !clk_o);
endmodule

// File: tb/tb_fracdiv_top.sv
`timescale 1ns/1ps
module tb_fracdiv_top;
    localparam int INT_W   = 8;
    localparam int FRAC_W  = 8;
    localparam int PHASE_W = 12;

    logic               clk_i = 1'b0;
    logic               rst_ni = 1'b0;
    logic               en_i = 1'b0;
    logic [INT_W-1:0]   whole_i = '0;
    logic [FRAC_W-1:0]  num_i = '0;
    logic [FRAC_W-1:0]  den_i = '0;
    logic               bypass_i = 1'b0;
    logic               clk_o;
    logic [PHASE_W-1:0] phase_err_o;
    logic               div_hi_o;
    logic               cfg_err_o;

    fracdiv_top #(.INT_W(INT_W), .FRAC_W(FRAC_W), .PHASE_W(PHASE_W)) dut (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .en_i        (en_i),
        .whole_i     (whole_i),
        .num_i       (num_i),
        .den_i       (den_i),
        .bypass_i    (bypass_i),
        .clk_o       (clk_o),
        .phase_err_o (phase_err_o),
        .div_hi_o    (div_hi_o),
        .cfg_err_o   (cfg_err_o)
    );

    always #10 clk_i = ~clk_i;   // 50 MHz

    typedef struct {
        int    d;
        bit    hi;
        int    ph;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   total = 0;
    int   bad   = 0;
    int   m_acc = 0;     // model residue
    int   prime_d = 0;
    bit   done = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
        end
    endtask

    // Driver helpers: drive after the rising edge.
    task automatic drive_cfg(input int w, input int n, input int d, input bit byp);
        @(posedge clk_i); #2;
        whole_i  = INT_W'(w);
        num_i    = FRAC_W'(n);
        den_i    = FRAC_W'(d);
        bypass_i = byp;
    endtask

    // Push n expected periods for the current ratio, advancing the model.
    task automatic push_periods(input int w, input int n, input int d, input bit byp, input int cnt);
        for (int k = 0; k < cnt; k++) begin
            exp_t it;
            if (byp) begin
                it.d = w; it.hi = 1'b0; it.ph = 0; it.tag = "R4";
            end else begin
                int s;
                s = m_acc + n;
                if (s >= d) begin
                    m_acc = s - d; it.d = w + 1; it.hi = 1'b1;
                end else begin
                    m_acc = s; it.d = w; it.hi = 1'b0;
                end
                it.ph  = (m_acc * (1 << PHASE_W)) / d;
                it.tag = "R1";
            end
            exp_q.push_back(it);
        end
    endtask

    task automatic start_run(input int w);
        m_acc   = 0;
        prime_d = w;
        @(posedge clk_i); #2;
        en_i = 1'b1;
    endtask

    task automatic stop_run();
        @(posedge clk_i); #2;
        en_i = 1'b0;
        exp_q.delete();
        repeat (2) @(negedge clk_i);
        chk(clk_o == 1'b0, "R9 low after disable", int'(clk_o), 0);
    endtask

    task automatic bad_cfg(input int w, input int n, input int d, input bit byp, input string req);
        int highs = 0;
        drive_cfg(w, n, d, byp);
        @(posedge clk_i); #2;
        en_i = 1'b1;
        repeat (2) @(negedge clk_i);
        chk(cfg_err_o == 1'b1, req, int'(cfg_err_o), 1);
        for (int k = 0; k < 24; k++) begin
            @(negedge clk_i);
            if (clk_o) highs++;
        end
        chk(highs == 0, {req, " output held low"}, highs, 0);
        @(posedge clk_i); #2;
        en_i = 1'b0;
    endtask

    // Monitor: measures periods and compares against the queue.
    int ncount = 0, en_n = 0, hi_cnt = 0, rise_n = 0, prev_d = 0;
    bit en_prev = 0, clko_prev = 0, first_pending = 0, have_prev = 0;
    string prev_tag = "R1";
    always @(negedge clk_i) begin
        ncount++;
        if (!rst_ni) begin
            en_prev = 0; clko_prev = 0; first_pending = 0; have_prev = 0;
        end else begin
            if (en_i && !en_prev) begin
                first_pending = 1; en_n = ncount; have_prev = 0;
            end
            if (!en_i) begin
                first_pending = 0; have_prev = 0;
            end
            if (clk_o && !clko_prev) begin
                if (first_pending)
                    chk(ncount - en_n == prime_d + 1, "R8 first edge delay",
                        ncount - en_n, prime_d + 1);
                first_pending = 0;
                if (have_prev) begin
                    chk(ncount - rise_n == prev_d, {prev_tag, "/R6 period length"},
                        ncount - rise_n, prev_d);
                    chk(hi_cnt == prev_d / 2, "R7 high time", hi_cnt, prev_d / 2);
                end
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R1 unexpected edge", 1, 0);
                    have_prev = 0;
                end else begin
                    exp_t it;
                    it = exp_q.pop_front();
                    chk(div_hi_o == it.hi, {it.tag, "/R5 divisor select"}, int'(div_hi_o), int'(it.hi));
                    chk(int'(phase_err_o) == it.ph, {it.tag, "/R2 phase word"}, int'(phase_err_o), it.ph);
                    prev_d = it.d; prev_tag = it.tag; have_prev = 1;
                    rise_n = ncount; hi_cnt = 1;
                end
            end else if (clk_o) begin
                hi_cnt++;
            end
            en_prev = en_i; clko_prev = clk_o;
        end
    end

    initial begin
        repeat (3) @(negedge clk_i);
        chk(clk_o == 0 && div_hi_o == 0 && phase_err_o == 0 && cfg_err_o == 0,
            "R8 reset state", int'(clk_o) + int'(div_hi_o) + int'(phase_err_o) + int'(cfg_err_o), 0);
        @(posedge clk_i); #2;
        rst_ni = 1'b1;

        // R1/R2/R5: full residue wrap with den 7.
        drive_cfg(8, 3, 7, 0);
        start_run(8);
        push_periods(8, 3, 7, 0, 14);
        wait (exp_q.size() == 0);
        stop_run();

        // R6: ratio change mid-period, residue carried over.
        drive_cfg(10, 0, 1, 0);
        start_run(10);
        push_periods(10, 0, 1, 0, 3);
        wait (exp_q.size() == 0);
        drive_cfg(9, 1, 2, 0);
        push_periods(9, 1, 2, 0, 6);
        wait (exp_q.size() == 0);
        stop_run();

        // R4/R6: bypass 4, then switch to 6 at a boundary.
        drive_cfg(4, 0, 0, 1);
        start_run(4);
        push_periods(4, 0, 0, 1, 6);
        wait (exp_q.size() == 0);
        drive_cfg(6, 0, 0, 1);
        push_periods(6, 0, 0, 1, 6);
        wait (exp_q.size() == 0);
        stop_run();

        // R9: disable mid-run, restart from residue 0.
        drive_cfg(12, 5, 9, 0);
        start_run(12);
        push_periods(12, 5, 9, 0, 6);
        wait (exp_q.size() <= 3);
        stop_run();
        start_run(12);
        push_periods(12, 5, 9, 0, 9);
        wait (exp_q.size() == 0);
        stop_run();

        // R1: widest ratio, upper divisor needs the extra bit.
        drive_cfg(255, 254, 255, 0);
        start_run(255);
        push_periods(255, 254, 255, 0, 5);
        wait (exp_q.size() == 0);
        stop_run();

        // R3/R4: illegal configurations.
        bad_cfg(7, 0, 1, 0, "R3 ratio below 8");
        bad_cfg(9, 4, 4, 0, "R3 num equals den");
        bad_cfg(9, 0, 0, 0, "R3 zero den");
        bad_cfg(5, 0, 0, 1, "R4 bypass 5");
        bad_cfg(8, 0, 0, 1, "R4 bypass 8");

        repeat (4) @(negedge clk_i);
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule